// File: doc/BRIEF.md
# SDRAM Column Burst Engine

This block models the column side of a single-bank SDR SDRAM as the device sees it. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable pins. From them it recognises three commands: read, write and burst stop. A command latches a starting column from the address pins. The engine then walks a burst of columns in sequential or interleaved order, for a length chosen by a mode input. Writes store the DQ input word into an internal column array. Reads fetch from the same array into a CAS-latency pipeline that drives the DQ output and its output enable.

A new command may cut into a burst that is still running. Words already in the read pipeline keep coming out after an interrupting read, write or burst stop. A separate output-mask input lets a controller silence those words when it turns the bus around for a write. Row activation, precharge, refresh and timing checks are left to other blocks. The mode inputs are expected to stay stable while a burst is running.

Top module: `sdr_col_burst`

## Requirements
- R1: Pins sampled at a rising edge with cs_n=0, ras_n=1, cas_n=0 and we_n=1 form a read. The read fetches the word stored at the starting column given on `addr`.
- R2: Pins cs_n=0, ras_n=1, cas_n=0 and we_n=0 form a write. The DQ input at the command edge is stored at the starting column, and the following burst words are stored on each following edge.
- R3: `bl_code` sets the burst length: 0→1, 1→2, 2→4, 3→8, 7→full page. Any other code acts as length 1. A full-page burst covers all 2^COL_W columns and wraps until a later command ends it. DQ input after a write burst has finished is not stored, and no read word follows the last beat of a read burst.
- R4: With `ilv_mode`=0, beat k addresses the starting column with its low log2(length) bits replaced by (start+k) mod length. The upper bits stay fixed.
- R5: With `ilv_mode`=1, beat k uses (start XOR k) in those low bits. A full-page burst is always sequential.
- R6: `cas_lat3`=0 selects latency 2 and 1 selects latency 3. A word issued at edge T is driven with `dq_oe`=1 from edge T+CL-1 until edge T+CL.
- R7: A read during a read burst drops the remaining beats and starts a full-length burst at the new column. Words issued before it still appear on DQ until the new read's data takes over.
- R8: A write during a write burst drops the remaining beats and writes a full-length burst from the new column.
- R9: A read during a write burst ends the write at that edge, and the DQ input at that edge and after it is not stored.
- R10: A burst stop ends any running read or write burst. After a stop at edge S, DQ is high impedance from edge S+CL-1 onward.
- R11: While `dqm` is 1, `dq_oe` is 0 in the same cycle. This lets the bus be released for the first two cycles of a write that interrupts a read.
- R12: During and straight after reset, `dq_oe` is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | COL_W | Starting column of a read or write |
| bl_code | input | 3 | Burst length code |
| ilv_mode | input | 1 | 1 selects interleaved order |
| cas_lat3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| dqm | input | 1 | Output mask; forces DQ to high impedance |
| dq_i | input | DW | DQ input word |
| dq_o | output | DW | DQ output word |
| dq_oe | output | 1 | DQ output enable |

## Verification
The bench builds the block with its default parameters: a 9-bit column (512 words) and a 16-bit data path. With these values a full-page write of 514 beats wraps past the last column and overwrites the first two, and every column can be preloaded before any read. Burst lengths 1 to 8 in both orders fit well inside the page. The bench can therefore place bursts that cross an alignment boundary only in their start, and check them against a column formula in the bench. Both latencies are exercised under interruption and stop, in directed and seeded random sequences.

// File: rtl/sdr_col_pkg.sv
package sdr_col_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_BST = 2'd3
    } cmd_e;

    localparam logic [2:0] BL_CODE_PAGE = 3'd7;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
    import sdr_col_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n && ras_n) begin
            unique case ({cas_n, we_n})
                2'b01:   cmd = CMD_RD;
                2'b00:   cmd = CMD_WR;
                2'b10:   cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] low_d;

    always_comb begin
        if (ilv) low_d = base ^ beat;
        else     low_d = base + beat;
        col = (base & ~wrap_mask) | (low_d & wrap_mask);
    end

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          cl3,
    output logic          out_vld,
    output logic [DW-1:0] dout
);

    localparam int STAGES    = 3;
    localparam int IDX_SHORT = STAGES - 2;
    localparam int IDX_LONG  = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0]         vld;
        logic [STAGES-1:0][DW-1:0] dat;
    } pipe_t;

    pipe_t p_d, p_q;

    always_comb begin
        p_d        = p_q;
        p_d.vld[0] = push;
        p_d.dat[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            p_d.vld[i] = p_q.vld[i-1];
            p_d.dat[i] = p_q.dat[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign out_vld = cl3 ? p_q.vld[IDX_LONG] : p_q.vld[IDX_SHORT];
    assign dout    = cl3 ? p_q.dat[IDX_LONG] : p_q.dat[IDX_SHORT];

    AST_CL2_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !cl3) |=> ##1 (out_vld || cl3)); // R6
    AST_CL3_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cl3) |=> ##2 (out_vld || !cl3)); // R6

endmodule

// File: rtl/sdr_col_burst.sv
module sdr_col_burst
    import sdr_col_pkg::*;
#(
    parameter int COL_W = 9,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [COL_W-1:0] addr,
    input  logic [2:0]       bl_code,
    input  logic             ilv_mode,
    input  logic             cas_lat3,
    input  logic             dqm,
    input  logic [DW-1:0]    dq_i,
    output logic [DW-1:0]    dq_o,
    output logic             dq_oe
);

    localparam int NCOL = 1 << COL_W;

    typedef struct packed {
        logic             rd_act;
        logic             wr_act;
        logic             page;
        logic             ilv;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] mask;
    } burst_t;

    function automatic logic [COL_W-1:0] len_mask(input logic [2:0] code);
        case (code)
            3'd1:         return COL_W'(1);
            3'd2:         return COL_W'(3);
            3'd3:         return COL_W'(7);
            BL_CODE_PAGE: return '1;
            default:      return '0;
        endcase
    endfunction

    cmd_e             cmd;
    burst_t           st_d, st_q;
    logic             rd_issue, wr_issue;
    logic [COL_W-1:0] g_base, g_cnt, g_mask;
    logic             g_ilv;
    logic [COL_W-1:0] col;
    logic [DW-1:0]    mem_q [NCOL];
    logic             pipe_vld;
    logic [DW-1:0]    pipe_dat;

    sdr_cmd_decode u_dec (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cmd  (cmd)
    );

    always_comb begin
        st_d     = st_q;
        rd_issue = 1'b0;
        wr_issue = 1'b0;
        g_base   = st_q.base;
        g_cnt    = st_q.cnt;
        g_mask   = st_q.mask;
        g_ilv    = st_q.ilv;
        case (cmd)
            CMD_RD, CMD_WR: begin
                st_d.base = addr;
                st_d.mask = len_mask(bl_code);
                st_d.page = (bl_code == BL_CODE_PAGE);
                st_d.ilv  = ilv_mode && (bl_code != BL_CODE_PAGE);
                st_d.cnt  = COL_W'(1);
                g_base    = addr;
                g_cnt     = '0;
                g_mask    = st_d.mask;
                g_ilv     = st_d.ilv;
                rd_issue  = (cmd == CMD_RD);
                wr_issue  = (cmd == CMD_WR);
                st_d.rd_act = (cmd == CMD_RD) && (st_d.mask != '0);
                st_d.wr_act = (cmd == CMD_WR) && (st_d.mask != '0);
            end
            CMD_BST: begin
                st_d.rd_act = 1'b0;
                st_d.wr_act = 1'b0;
            end
            default: begin
                rd_issue = st_q.rd_act;
                wr_issue = st_q.wr_act;
                if (st_q.rd_act || st_q.wr_act) begin
                    st_d.cnt = st_q.cnt + COL_W'(1);
                    if (!st_q.page && (st_q.cnt == st_q.mask)) begin
                        st_d.rd_act = 1'b0;
                        st_d.wr_act = 1'b0;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sdr_col_gen #(.COL_W(COL_W)) u_col (
        .base     (g_base),
        .beat     (g_cnt),
        .wrap_mask(g_mask),
        .ilv      (g_ilv),
        .col      (col)
    );

    always_ff @(posedge clk) begin
        if (wr_issue) mem_q[col] <= dq_i;
    end

    sdr_rd_pipe #(.DW(DW)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (rd_issue),
        .din    (mem_q[col]),
        .cl3    (cas_lat3),
        .out_vld(pipe_vld),
        .dout   (pipe_dat)
    );

    assign dq_o  = pipe_dat;
    assign dq_oe = pipe_vld && !dqm;

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.rd_act && st_q.wr_act)); // R9
    AST_RD_ENDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD) |=> !st_q.wr_act); // R9
    AST_BST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_BST) |=> !(st_q.rd_act || st_q.wr_act)); // R10
    AST_BL1_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_RD || cmd == CMD_WR) && bl_code == 3'd0) |=> !(st_q.rd_act || st_q.wr_act)); // R3

endmodule

// File: tb/sdr_col_burst_bench.sv
`timescale 1ns/1ps
module sdr_col_burst_bench;

    localparam int COL_W = 9;
    localparam int DW    = 16;
    localparam int NCOL  = 512;
    localparam int NCYC  = 8192;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n, cs_n, ras_n, cas_n, we_n, ilv_mode, cas_lat3, dqm;
    logic [COL_W-1:0] addr;
    logic [2:0]       bl_code;
    logic [DW-1:0]    dq_i, dq_o;
    logic             dq_oe;

    sdr_col_burst #(.COL_W(COL_W), .DW(DW)) u_sdr_col_burst (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr(addr), .bl_code(bl_code), .ilv_mode(ilv_mode),
        .cas_lat3(cas_lat3), .dqm(dqm), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    int    n_chk = 0;
    int    n_err = 0;
    int    ecyc  = 0;
    int    cl_now = 2;
    bit    done = 0;
    bit    desel = 0;
    string cur_req = "R12";

    logic [DW-1:0] ref_mem [NCOL];
    bit            exp_oe  [NCYC];
    logic [DW-1:0] exp_dq  [NCYC];

    bit m_rd, m_wr, m_ilv;
    int m_base, m_k, m_len;

    localparam int C_NOP = 0, C_RD = 1, C_WR = 2, C_BST = 3;

    function automatic int bl_len(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return NCOL;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int base, input int k, input int len, input bit ilv);
        int m  = len - 1;
        int lo = (ilv && len != NCOL) ? ((base ^ k) & m) : ((base + k) & m);
        return (base & ~m & (NCOL - 1)) | lo;
    endfunction

    task automatic issue_rd(input int col);
        int t = ecyc + cl_now;
        exp_oe[t] = 1'b1;
        exp_dq[t] = ref_mem[col];
    endtask

    task automatic model_edge(input int cmd, input int a, input logic [DW-1:0] d);
        int col;
        if (cmd == C_RD || cmd == C_WR) begin
            m_base = a;
            m_len  = bl_len(bl_code);
            m_ilv  = ilv_mode;
            col    = exp_col(m_base, 0, m_len, m_ilv);
            if (cmd == C_RD) issue_rd(col);
            else             ref_mem[col] = d;
            m_k  = 1;
            m_rd = (cmd == C_RD) && (m_len > 1);
            m_wr = (cmd == C_WR) && (m_len > 1);
        end else if (cmd == C_BST) begin
            m_rd = 0;
            m_wr = 0;
        end else if (m_rd || m_wr) begin
            col = exp_col(m_base, m_k, m_len, m_ilv);
            if (m_rd) issue_rd(col);
            else      ref_mem[col] = d;
            m_k = (m_k + 1) % NCOL;
            if (m_len != NCOL && m_k == m_len) begin
                m_rd = 0;
                m_wr = 0;
            end
        end
    endtask

    task automatic cyc(input int cmd, input int a, input logic [DW-1:0] d, input bit m);
        bit eo;
        cs_n  = (cmd == C_NOP) ? desel : 1'b0;
        ras_n = 1'b1;
        cas_n = !(cmd == C_RD || cmd == C_WR);
        we_n  = !(cmd == C_WR || cmd == C_BST);
        addr  = COL_W'(a);
        dq_i  = d;
        dqm   = m;
        cas_lat3 = (cl_now == 3);
        model_edge(cmd, a, d);
        @(posedge clk);
        ecyc++;
        @(negedge clk);
        eo = exp_oe[ecyc] && !m;
        n_chk++;
        if (dq_oe !== eo) begin
            n_err++;
            $display("FAIL %s cycle %0d: dq_oe=%b expected %b", cur_req, ecyc, dq_oe, eo);
        end else if (eo && dq_o !== exp_dq[ecyc]) begin
            n_err++;
            $display("FAIL %s cycle %0d: dq_o=%h expected %h", cur_req, ecyc, dq_o, exp_dq[ecyc]);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(C_NOP, 0, 16'h0, 0);
    endtask

    task automatic rd_burst(input int a, input logic [2:0] bl, input bit ilv, input int gap);
        bl_code = bl; ilv_mode = ilv;
        cyc(C_RD, a, 16'h0, 0);
        idle(gap);
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(16'hA000 ^ (i * 37));
    endfunction

    initial begin
        for (int i = 0; i < NCYC; i++) begin exp_oe[i] = 0; exp_dq[i] = '0; end
        for (int i = 0; i < NCOL; i++) ref_mem[i] = '0;
        void'($urandom(32'd20240611));
        rst_n = 0; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; addr = '0;
        bl_code = 3'd3; ilv_mode = 0; cas_lat3 = 0; dqm = 0; dq_i = '0;
        m_rd = 0; m_wr = 0; m_ilv = 0; m_base = 0; m_k = 0; m_len = 1;
        repeat (3) @(negedge clk);
        n_chk++;
        if (dq_oe !== 1'b0) begin
            n_err++;
            $display("FAIL R12: dq_oe=%b expected 0 in reset", dq_oe);
        end
        rst_n = 1;
        cur_req = "R12";
        idle(3);

        // R2 / R3: full-page write wraps over the page end
        cur_req = "R2";
        bl_code = 3'd7;
        cyc(C_WR, 0, pat(0), 0);
        for (int i = 1; i < NCOL + 2; i++) cyc(C_NOP, 0, pat(i), 0);
        cyc(C_BST, 0, 16'hdead, 0);
        idle(3);
        cur_req = "R3";
        rd_burst(0, 3'd3, 0, 10);
        rd_burst(508, 3'd3, 0, 10);

        // R1 / R6: plain reads at latency 2
        cur_req = "R1";
        rd_burst(16, 3'd3, 0, 10);
        // R4: sequential order with wrap inside the aligned block
        cur_req = "R4";
        rd_burst(6, 3'd2, 0, 6);
        rd_burst(13, 3'd3, 0, 10);
        rd_burst(33, 3'd1, 0, 4);
        // R5: interleaved order; full page ignores it
        cur_req = "R5";
        rd_burst(5, 3'd3, 1, 10);
        rd_burst(3, 3'd2, 1, 6);
        bl_code = 3'd7; ilv_mode = 1;
        cyc(C_RD, 510, 16'h0, 0);
        idle(5);
        cyc(C_BST, 0, 16'h0, 0);
        idle(4);
        // R3: short lengths, reserved code, write data past the end
        cur_req = "R3";
        rd_burst(21, 3'd0, 0, 4);
        rd_burst(22, 3'd5, 0, 4);
        bl_code = 3'd1; ilv_mode = 0;
        cyc(C_WR, 40, 16'h1111, 0);
        cyc(C_NOP, 0, 16'h2222, 0);
        cyc(C_NOP, 0, 16'h3333, 0);
        cyc(C_NOP, 0, 16'h4444, 0);
        rd_burst(40, 3'd2, 0, 6);

        // R6: latency 3
        cur_req = "R6";
        cl_now = 3;
        idle(1);
        rd_burst(100, 3'd3, 0, 11);
        rd_burst(97, 3'd2, 1, 8);

        // R7: read interrupts read, both latencies
        cur_req = "R7";
        for (int c = 2; c <= 3; c++) begin
            cl_now = c;
            idle(4);
            bl_code = 3'd3; ilv_mode = 0;
            cyc(C_RD, 0, 16'h0, 0);
            idle(2);
            cyc(C_RD, 100, 16'h0, 0);
            idle(11);
        end

        // R8: write interrupts write
        cur_req = "R8";
        cl_now = 2;
        bl_code = 3'd2;
        cyc(C_WR, 200, 16'h8001, 0);
        cyc(C_NOP, 0, 16'h8002, 0);
        cyc(C_WR, 300, 16'h8101, 0);
        for (int i = 1; i < 6; i++) cyc(C_NOP, 0, DW'(16'h8101 + i), 0);
        rd_burst(200, 3'd2, 0, 6);
        rd_burst(300, 3'd2, 0, 6);

        // R9: read interrupts write
        cur_req = "R9";
        bl_code = 3'd3;
        cyc(C_WR, 220, 16'h9001, 0);
        cyc(C_NOP, 0, 16'h9002, 0);
        cyc(C_RD, 220, 16'h9003, 0);
        cyc(C_NOP, 0, 16'h9004, 0);
        idle(10);
        rd_burst(220, 3'd3, 0, 10);

        // R10: burst stop on read at both latencies and on write
        cur_req = "R10";
        for (int c = 2; c <= 3; c++) begin
            cl_now = c;
            idle(4);
            bl_code = 3'd3;
            cyc(C_RD, 50, 16'h0, 0);
            idle(3);
            cyc(C_BST, 0, 16'h0, 0);
            idle(6);
        end
        cyc(C_WR, 60, 16'hA001, 0);
        cyc(C_NOP, 0, 16'hA002, 0);
        cyc(C_BST, 0, 16'hA003, 0);
        cyc(C_NOP, 0, 16'hA004, 0);
        rd_burst(60, 3'd3, 0, 11);

        // R11: write cuts into a latency-3 read, masked for two cycles
        cur_req = "R11";
        bl_code = 3'd3;
        cyc(C_RD, 70, 16'h0, 0);
        idle(2);
        cyc(C_WR, 80, 16'hB000, 1);
        cyc(C_NOP, 0, 16'hB001, 1);
        for (int i = 2; i < 8; i++) cyc(C_NOP, 0, DW'(16'hB000 + i), 0);
        idle(2);
        rd_burst(80, 3'd3, 0, 11);

        // Seeded random mix over both latencies (R1 R4 R5 R7 R8 R9 R10 R11)
        cur_req = "R7";
        for (int seg = 0; seg < 4; seg++) begin
            idle(5);
            cl_now = (seg % 2 == 0) ? 2 : 3;
            idle(1);
            for (int i = 0; i < 400; i++) begin
                int r = $urandom_range(0, 99);
                int cmd = (r < 10) ? C_RD : (r < 18) ? C_WR : (r < 22) ? C_BST : C_NOP;
                int bsel = $urandom_range(0, 5);
                if (cmd == C_RD || cmd == C_WR) begin
                    bl_code  = (bsel == 4) ? 3'd7 : (bsel == 5) ? 3'd6 : 3'(bsel);
                    ilv_mode = 1'($urandom_range(0, 1));
                end
                desel = ($urandom_range(0, 3) == 0);
                cyc(cmd, $urandom_range(0, NCOL - 1), DW'($urandom()),
                    ($urandom_range(0, 9) == 0));
            end
            desel = 0;
            cyc(C_BST, 0, 16'h0, 0);
        end
        idle(6);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(100000 * 4);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule